// File: doc/BRIEF.md
# Strided Two-Dimensional Copy Engine with Completion Record

The engine copies bytes from one region of memory to another and then posts a completion record. Software-side setup arrives as configuration inputs: source and destination base addresses, a line length in bytes, a line count, separate source and destination strides, and a completion-record address and payload. All of these are captured when a launch pulse is accepted. In single-line mode one run of `line_len_i` bytes is moved. In multi-line mode the engine walks `line_cnt_i` lines, and each side advances by its own stride after every line. When both strides equal the line length, the walk folds into one contiguous run.

All traffic passes over one byte-wide memory port with valid/ready handshakes. A read is accepted in the same cycle its data is returned. A write is accepted on its handshake. After the last data byte has been written, the engine writes a completion record, which takes one of two forms. The short form holds only the payload. The long form holds the payload plus a 64-bit snapshot of an internal cycle counter, and the snapshot is written first. A launch that asks for component remapping or for a reduction is flagged on a status output and is not carried out in that form.

Top module: `dma2d_engine`

## Requirements
- R1: With `multi_line_i` low, a launch reads `line_len_i` bytes from `src_base_i` upward and writes each one to the same offset above `dst_base_i`, in ascending order. The line count and the strides are ignored.
- R2: With `multi_line_i` high, line k (0 ≤ k < `line_cnt_i`) reads from `src_base_i + k*src_pitch_i` and writes to `dst_base_i + k*dst_pitch_i`, `line_len_i` bytes each, ascending, with lines taken in order.
- R3: When both strides equal `line_len_i` in multi-line mode, reads and writes cover `line_len_i*line_cnt_i` consecutive ascending addresses from the respective bases.
- R4: Completion-record writes start only after the last data write has been accepted, and no data write follows them.
- R5: `sem_mode_i` = 1 (short form) writes the 4 payload bytes, little-endian, to `sem_addr_i .. sem_addr_i+3` and nothing else.
- R6: `sem_mode_i` = 2 (long form) first writes the 8 timestamp bytes, little-endian, to `sem_addr_i+8 .. sem_addr_i+15`, then the payload as in R5. The timestamp is the count of clock cycles since reset release, sampled between the launch and the end of the run, and it strictly increases from one launch to the next.
- R7: With `remap_i` set at launch, no data is moved but the completion record is still written. With `reduce_i` set, the copy runs normally and the record is written as a plain record. Either case raises `unsup_o`, which holds its value until the next accepted launch, and an accepted launch with neither bit set clears it.
- R8: A launch with `line_len_i` = 0, or with multi-line set and `line_cnt_i` = 0, issues no read or data write but still writes the completion record.
- R9: `busy_o` rises in the cycle after an accepted launch and stays high until the last write has been accepted. A launch while busy is ignored, and no second run follows it.
- R10: `sem_mode_i` = 0 or 3 writes no completion record.
- R11: A read or write held valid without ready keeps its valid, address and data unchanged, and a read and a write are never valid together.
- R12: While reset is asserted, `busy_o`, `unsup_o`, `rd_valid_o` and `wr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Launch pulse, accepted only when idle |
| multi_line_i | input | 1 | Multi-line mode select |
| remap_i | input | 1 | Remap request (unsupported) |
| reduce_i | input | 1 | Reduction request (unsupported) |
| sem_mode_i | input | 2 | 0 none, 1 short record, 2 long record, 3 none |
| src_base_i | input | ADDR_W | Source base address |
| dst_base_i | input | ADDR_W | Destination base address |
| src_pitch_i | input | ADDR_W | Source stride per line |
| dst_pitch_i | input | ADDR_W | Destination stride per line |
| sem_addr_i | input | ADDR_W | Completion-record address |
| line_len_i | input | LEN_W | Bytes per line |
| line_cnt_i | input | CNT_W | Number of lines |
| sem_payload_i | input | PAY_W | Completion payload |
| busy_o | output | 1 | Run in progress |
| unsup_o | output | 1 | Last accepted launch asked for an unsupported operation |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_ready_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 8 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 8 | Write data |
| wr_ready_i | input | 1 | Write accepted |

## Verification
Two events can meet in one cycle: the handshake on the final data byte, and the switch to the completion-record writer. A new launch can also arrive in the same window while the engine is still busy. The bench stalls both ready signals at random and fires a second launch with a different configuration shortly after the first. It then compares the full write log against a stream computed from the first configuration only: data bytes first, then exactly the record bytes, with no extra run after busy falls. Timestamps are judged against a window taken from the bench's own cycle count.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    SEM_NONE = 2'd0,
    SEM_ONE  = 2'd1,
    SEM_FOUR = 2'd2,
    SEM_RSVD = 2'd3
  } sem_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_KICK = 3'd3,
    ST_SEM  = 3'd4
  } state_e;

  localparam int unsigned TS_OFF = 8;
endpackage

// File: rtl/dma2d_timebase.sv
module dma2d_timebase #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else         count_o <= count_o + TS_W'(1);
  end
endmodule

// File: rtl/dma2d_line_walker.sv
module dma2d_line_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              flat_i,
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [ADDR_W-1:0] src_pitch_i,
  input  logic [ADDR_W-1:0] dst_pitch_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              last_o
);
  localparam int unsigned TOT_W = LEN_W + CNT_W;

  logic [ADDR_W-1:0] line_src_q, line_dst_q, src_pitch_q, dst_pitch_q;
  logic [TOT_W-1:0]  run_len_q, byte_q;
  logic [CNT_W-1:0]  lines_q, line_q;
  logic              line_end;

  assign line_end   = byte_q == run_len_q - TOT_W'(1);
  assign last_o     = line_end && (line_q == lines_q - CNT_W'(1));
  assign src_addr_o = line_src_q + ADDR_W'(byte_q);
  assign dst_addr_o = line_dst_q + ADDR_W'(byte_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_src_q  <= '0;
      line_dst_q  <= '0;
      src_pitch_q <= '0;
      dst_pitch_q <= '0;
      run_len_q   <= '0;
      byte_q      <= '0;
      lines_q     <= '0;
      line_q      <= '0;
    end else if (load_i) begin
      line_src_q  <= src_base_i;
      line_dst_q  <= dst_base_i;
      src_pitch_q <= src_pitch_i;
      dst_pitch_q <= dst_pitch_i;
      // equal strides: one run covering every line
      run_len_q   <= flat_i ? TOT_W'(len_i) * TOT_W'(cnt_i) : TOT_W'(len_i);
      lines_q     <= (multi_i && !flat_i) ? cnt_i : CNT_W'(1);
      byte_q      <= '0;
      line_q      <= '0;
    end else if (step_i) begin
      if (line_end) begin
        byte_q     <= '0;
        line_q     <= line_q + CNT_W'(1);
        line_src_q <= line_src_q + src_pitch_q;
        line_dst_q <= line_dst_q + dst_pitch_q;
      end else begin
        byte_q <= byte_q + TOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma2d_sem_writer.sv
module dma2d_sem_writer
  import dma2d_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAY_W  = 32,
  parameter int unsigned TS_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              four_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAY_W-1:0]  payload_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o
);
  localparam int unsigned NTS   = TS_W / 8;
  localparam int unsigned NPL   = PAY_W / 8;
  localparam int unsigned NTOT  = NTS + NPL;
  localparam int unsigned IDX_W = $clog2(NTOT);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q, pidx;
  logic [ADDR_W-1:0] addr_q;
  logic [PAY_W-1:0]  pay_q, pay_sh;
  logic [TS_W-1:0]   ts_q, ts_sh;
  logic              in_ts, at_end;

  assign in_ts  = idx_q < IDX_W'(NTS);
  assign at_end = idx_q == IDX_W'(NTOT - 1);
  assign pidx   = idx_q - IDX_W'(NTS);
  assign ts_sh  = ts_q >> {idx_q, 3'b000};
  assign pay_sh = pay_q >> {pidx, 3'b000};

  assign wr_valid_o = active_q;
  assign wr_addr_o  = in_ts ? addr_q + ADDR_W'(TS_OFF) + ADDR_W'(idx_q)
                            : addr_q + ADDR_W'(pidx);
  assign wr_data_o  = in_ts ? ts_sh[7:0] : pay_sh[7:0];
  assign done_o     = active_q && wr_ready_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      pay_q    <= '0;
      ts_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      // short record skips the timestamp bytes
      idx_q    <= four_i ? '0 : IDX_W'(NTS);
      addr_q   <= addr_i;
      pay_q    <= payload_i;
      ts_q     <= ts_i;
    end else if (active_q && wr_ready_i) begin
      if (at_end) active_q <= 1'b0;
      else        idx_q    <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
  import dma2d_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PAY_W  = 32,
  parameter int unsigned TS_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              multi_line_i,
  input  logic              remap_i,
  input  logic              reduce_i,
  input  logic [1:0]        sem_mode_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [ADDR_W-1:0] src_pitch_i,
  input  logic [ADDR_W-1:0] dst_pitch_i,
  input  logic [ADDR_W-1:0] sem_addr_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [CNT_W-1:0]  line_cnt_i,
  input  logic [PAY_W-1:0]  sem_payload_i,
  output logic              busy_o,
  output logic              unsup_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  input  logic              wr_ready_i
);
  state_e            state_q;
  logic              accept, empty, sem_req, flat;
  logic              sem_four_q, sem_en_q, unsup_q;
  logic [ADDR_W-1:0] sem_addr_q;
  logic [PAY_W-1:0]  pay_q;
  logic [7:0]        byte_q;
  logic [ADDR_W-1:0] walk_src, walk_dst;
  logic              walk_last, walk_step;
  logic [TS_W-1:0]   now;
  logic              sem_valid, sem_done;
  logic [ADDR_W-1:0] sem_waddr;
  logic [7:0]        sem_wdata;

  assign accept    = launch_i && (state_q == ST_IDLE);
  assign empty     = remap_i || (line_len_i == '0) || (multi_line_i && (line_cnt_i == '0));
  assign sem_req   = (sem_mode_i == SEM_ONE) || (sem_mode_i == SEM_FOUR);
  assign flat      = multi_line_i && (src_pitch_i == dst_pitch_i)
                     && (src_pitch_i == ADDR_W'(line_len_i));
  assign walk_step = (state_q == ST_WR) && wr_ready_i && !walk_last;

  dma2d_timebase #(.TS_W(TS_W)) u_time (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_o (now)
  );

  dma2d_line_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .flat_i      (flat),
    .multi_i     (multi_line_i),
    .src_base_i  (src_base_i),
    .dst_base_i  (dst_base_i),
    .src_pitch_i (src_pitch_i),
    .dst_pitch_i (dst_pitch_i),
    .len_i       (line_len_i),
    .cnt_i       (line_cnt_i),
    .step_i      (walk_step),
    .src_addr_o  (walk_src),
    .dst_addr_o  (walk_dst),
    .last_o      (walk_last)
  );

  dma2d_sem_writer #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .TS_W(TS_W)) u_sem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (state_q == ST_KICK),
    .four_i     (sem_four_q),
    .addr_i     (sem_addr_q),
    .payload_i  (pay_q),
    .ts_i       (now),
    .wr_ready_i (wr_ready_i),
    .wr_valid_o (sem_valid),
    .wr_addr_o  (sem_waddr),
    .wr_data_o  (sem_wdata),
    .done_o     (sem_done)
  );

  assign busy_o     = state_q != ST_IDLE;
  assign unsup_o    = unsup_q;
  assign rd_valid_o = state_q == ST_RD;
  assign rd_addr_o  = walk_src;
  assign wr_valid_o = (state_q == ST_WR) || sem_valid;
  assign wr_addr_o  = (state_q == ST_WR) ? walk_dst : sem_waddr;
  assign wr_data_o  = (state_q == ST_WR) ? byte_q : sem_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      unsup_q    <= 1'b0;
      sem_four_q <= 1'b0;
      sem_en_q   <= 1'b0;
      sem_addr_q <= '0;
      pay_q      <= '0;
      byte_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          unsup_q    <= remap_i || reduce_i;
          sem_four_q <= sem_mode_i == SEM_FOUR;
          sem_en_q   <= sem_req;
          sem_addr_q <= sem_addr_i;
          pay_q      <= sem_payload_i;
          if (!empty)       state_q <= ST_RD;
          else if (sem_req) state_q <= ST_KICK;
        end
        ST_RD: if (rd_ready_i) begin
          byte_q  <= rd_data_i;
          state_q <= ST_WR;
        end
        ST_WR: if (wr_ready_i) begin
          if (!walk_last)    state_q <= ST_RD;
          else if (sem_en_q) state_q <= ST_KICK;
          else               state_q <= ST_IDLE;
        end
        ST_KICK: state_q <= ST_SEM;
        ST_SEM:  if (sem_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_engine_chk.sv
module dma2d_engine_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              launch_i,
  input logic              busy_o,
  input logic              unsup_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        wr_data_o
);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  p_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_valid_o && !wr_valid_o);

  p_unsup_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_i && !busy_o) |=> $stable(unsup_o));

  p_reset_r12: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !unsup_o && !rd_valid_o && !wr_valid_o);
endmodule

bind dma2d_engine dma2d_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .launch_i   (launch_i),
  .busy_o     (busy_o),
  .unsup_o    (unsup_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/sim_dma2d_engine.sv
module sim_dma2d_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch = 1'b0, multi = 1'b0, remap = 1'b0, reduce = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] src = '0, dst = '0, sp = '0, dp = '0, saddr = '0, pay = '0;
  logic [15:0] len = '0, cnt = '0;
  logic        busy, unsup, rd_valid, wr_valid;
  logic        rd_ready = 1'b1, wr_ready = 1'b1;
  logic [31:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;

  int checks = 0, errors = 0, cyc = 0, cyc0 = 0;
  bit stall = 1'b0;
  int both_err = 0, hold_err = 0;
  bit rd_pend = 1'b0, wr_pend = 1'b0;
  logic [31:0] rd_pa, wr_pa;
  logic [7:0]  wr_pd;

  logic [31:0] wlog_a [LOGN];
  logic [7:0]  wlog_d [LOGN];
  logic [31:0] rlog_a [LOGN];
  int wn = 0, rn = 0;

  logic [31:0] ea [LOGN];
  logic [7:0]  ed [LOGN];
  bit          ets [LOGN];
  logic [31:0] era [LOGN];
  int en = 0, ern = 0, e_data_n = 0;
  logic [1:0] exp_mode;
  longint t_launch = 0, t_done = 0, last_ts = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [31:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h3c;
  endfunction

  assign rd_data = src_byte(rd_addr);

  dma2d_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .multi_line_i(multi),
    .remap_i(remap), .reduce_i(reduce), .sem_mode_i(mode),
    .src_base_i(src), .dst_base_i(dst), .src_pitch_i(sp), .dst_pitch_i(dp),
    .sem_addr_i(saddr), .line_len_i(len), .line_cnt_i(cnt), .sem_payload_i(pay),
    .busy_o(busy), .unsup_o(unsup),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready)
  );

  // ready for the next edge is chosen first, then that edge's handshakes are logged
  always @(negedge clk) begin
    cyc++;
    rd_ready = stall ? (($urandom % 4) != 0) : 1'b1;
    wr_ready = stall ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n) begin
      if (rd_valid && wr_valid) both_err++;
      if (rd_pend && (!rd_valid || rd_addr != rd_pa)) hold_err++;
      if (wr_pend && (!wr_valid || wr_addr != wr_pa || wr_data != wr_pd)) hold_err++;
      if (rd_valid && rd_ready && rn < LOGN) begin rlog_a[rn] = rd_addr; rn++; end
      if (wr_valid && wr_ready && wn < LOGN) begin
        wlog_a[wn] = wr_addr; wlog_d[wn] = wr_data; wn++;
      end
      rd_pend = rd_valid && !rd_ready; rd_pa = rd_addr;
      wr_pend = wr_valid && !wr_ready; wr_pa = wr_addr; wr_pd = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic build_exp();
    bit e;
    int lines;
    logic [31:0] a;
    e = remap || (len == 0) || (multi && cnt == 0);
    lines = multi ? int'(cnt) : 1;
    en = 0; ern = 0; exp_mode = mode;
    if (!e) begin
      for (int l = 0; l < lines; l++) begin
        for (int b = 0; b < int'(len); b++) begin
          a = src + sp * l + b;
          era[ern] = a; ern++;
          ea[en] = dst + dp * l + b; ed[en] = src_byte(a); ets[en] = 1'b0; en++;
        end
      end
    end
    e_data_n = en;
    if (mode == 2'd2) begin
      for (int i = 0; i < 8; i++) begin
        ea[en] = saddr + 8 + i; ed[en] = 8'h00; ets[en] = 1'b1; en++;
      end
    end
    if (mode == 2'd1 || mode == 2'd2) begin
      for (int i = 0; i < 4; i++) begin
        ea[en] = saddr + i; ed[en] = pay[8*i +: 8]; ets[en] = 1'b0; en++;
      end
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    launch = 1'b1;
    t_launch = cyc - cyc0;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk(1'b0, "R9", "run never ended", t, 0);
    t_done = cyc - cyc0;
  endtask

  task automatic verify(input string req);
    int bad_d, bad_s;
    string sreq;
    longint ts;
    sreq = (exp_mode == 2'd2) ? "R6" : (exp_mode == 2'd1) ? "R5" : "R10";
    chk(wn == en, req, "write count", wn, en);
    chk(rn == ern, req, "read count", rn, ern);
    bad_d = -1; bad_s = -1;
    for (int i = 0; i < en && i < wn; i++) begin
      if (wlog_a[i] != ea[i] || (!ets[i] && wlog_d[i] != ed[i])) begin
        if (i < e_data_n && bad_d < 0) bad_d = i;
        if (i >= e_data_n && bad_s < 0) bad_s = i;
      end
    end
    if (bad_d >= 0) chk(1'b0, req, "data write addr", wlog_a[bad_d], ea[bad_d]);
    else chk(1'b1, req, "data writes", 0, 0);
    if (bad_s >= 0) chk(1'b0, sreq, "record write addr", wlog_a[bad_s], ea[bad_s]);
    else chk(1'b1, sreq, "record writes", 0, 0);
    for (int i = 0; i < rn && i < ern; i++) begin
      if (rlog_a[i] != era[i]) begin
        chk(1'b0, req, "read addr", rlog_a[i], era[i]);
        break;
      end
    end
    if (exp_mode != 2'd0 && wn == en) begin
      // R4: the first record byte sits right after the last data byte
      chk(wlog_a[e_data_n] == ea[e_data_n], "R4", "record after data", wlog_a[e_data_n], ea[e_data_n]);
    end
    if (exp_mode == 2'd2 && wn >= e_data_n + 8) begin
      ts = 0;
      for (int i = 7; i >= 0; i--) ts = (ts << 8) | longint'(wlog_d[e_data_n + i]);
      chk(ts >= t_launch - 3 && ts <= t_done + 3 && ts > last_ts, "R6", "timestamp window", ts, t_launch);
      last_ts = ts;
    end
  endtask

  task automatic run(input string req);
    bit expect_busy;
    expect_busy = !(remap || len == 0 || (multi && cnt == 0)) || mode == 2'd1 || mode == 2'd2;
    wn = 0; rn = 0;
    build_exp();
    pulse();
    if (expect_busy) chk(busy == 1'b1, "R9", "busy after launch", busy, 1);
    wait_idle();
    verify(req);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "WD", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid && !unsup, "R12", "reset outputs",
        {busy, rd_valid, wr_valid, unsup}, 0);
    rst_n = 1'b1;
    cyc0 = cyc;
    stall = 1'b1;
    repeat (2) @(negedge clk);

    // R1: single line; count and strides must not matter
    multi = 0; len = 5; cnt = 3; sp = 100; dp = 200;
    src = 32'h100; dst = 32'h2000; saddr = 32'h8000; pay = 32'ha1b2c3d4; mode = 2'd1;
    run("R1");

    // R2 sweep; equal strides fold into a contiguous run (R3)
    multi = 1; mode = 2'd2; pay = 32'h1234_5678;
    for (int l = 1; l <= 4; l++)
      for (int c = 1; c <= 3; c++)
        for (int k = 0; k < 3; k++)
          for (int j = 0; j < 3; j++) begin
            len = 16'(l); cnt = 16'(c); sp = 32'(l + k); dp = 32'(l + j * 2);
            src = 32'h400 + 32'(l * 16 + c); dst = 32'h3000 + 32'(k * 64);
            saddr = 32'h9000 + 32'(j * 32);
            run((k == 0 && j == 0) ? "R3" : "R2");
          end

    // R3 larger contiguous case, no record (R10)
    len = 8; cnt = 4; sp = 8; dp = 8; src = 32'h1f0; dst = 32'h5000; mode = 2'd0;
    run("R3");
    mode = 2'd3; len = 3; cnt = 2; sp = 5; dp = 7;
    run("R10");

    // R7 remap: no data, record written, flag raised
    remap = 1; mode = 2'd1; len = 4; cnt = 2; sp = 6; dp = 6; saddr = 32'ha000;
    run("R7");
    chk(unsup == 1'b1, "R7", "unsup after remap", unsup, 1);
    remap = 0;

    // R7 reduce: copy carried out, plain record, flag raised
    reduce = 1; multi = 0; len = 3; mode = 2'd2;
    run("R7");
    chk(unsup == 1'b1, "R7", "unsup after reduce", unsup, 1);
    reduce = 0;
    run("R1");
    chk(unsup == 1'b0, "R7", "unsup cleared", unsup, 0);

    // R8 empty launches
    multi = 0; len = 0; mode = 2'd1; pay = 32'hcafe_f00d;
    run("R8");
    multi = 1; len = 4; cnt = 0; mode = 2'd2;
    run("R8");

    // R9 launch while busy is ignored
    multi = 0; len = 6; mode = 2'd1; src = 32'h700; dst = 32'h7700; saddr = 32'hb000;
    wn = 0; rn = 0;
    build_exp();
    pulse();
    src = 32'h50; dst = 32'h6000; len = 9; mode = 2'd2; saddr = 32'hc000;
    pulse();
    wait_idle();
    verify("R9");
    repeat (20) @(negedge clk);
    chk(!busy && wn == en && rn == ern, "R9", "no second run", wn, en);

    chk(both_err == 0, "R11", "read and write valid together", both_err, 0);
    chk(hold_err == 0, "R11", "request changed while stalled", hold_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule